// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block is a bank of eight 32-bit performance counters that a cache slice uses to count activity. Each counter has an event-type register that picks one of 256 event input lines. It advances by one on every clock in which that line is high, provided the unit-wide enable and its own enable bit are set. Software sets up and reads the bank through a simple register port. Writes take effect on the clock edge. A read strobe returns its data one cycle later, flagged by a valid output.

An odd-numbered counter can be ganged to its even neighbour. It then counts the carry-outs of that neighbour instead of its own event, and the pair forms one 64-bit counter. A sticky overflow status register records each counter's wrap. A counter can also be set to record every change of its bit 31, so a free-running 32-bit count needs no reprogramming. One interrupt line is the OR of the overflow status bits whose interrupt enable is set.

Top module: `evcnt_bank`

## Requirements
- R1: After reset every counter value, event selector, counter-enable mask, interrupt-enable mask, gang register, MSB-mode register and overflow status bit is 0, and `irqOut` is low.
- R2: Counter n advances by exactly one on each clock where the unit enable (bit 0 at 0x500) is 1, its counter-enable bit n is 1, and the event input picked by bits [7:0] of its selector at 0x220+8n is high. A selector value of 0 never counts an event. The selector reads back at its address.
- R3: Writing 0x508 sets and writing 0x50C clears counter-enable bits, and writing 0x510 sets and writing 0x514 clears interrupt-enable bits. Bit n refers to counter n, and 0 bits leave the state unchanged. Reading either address of a pair returns the current mask.
- R4: While bit 0 at 0x500 is 0, no counter advances. Writing 0x500 with bit 1 set clears every counter value on that edge. Bit 1 always reads back as 0.
- R5: The counter value at 0x420+8n is readable and writable. A software write wins over an increment in the same cycle.
- R6: Setting odd bit n of the gang register at 0x718 makes counter n advance on each wrap of counter n-1, in the same clock as the wrap, and no longer on its own event. Even bits are dropped and read as 0.
- R7: A wrap of counter n from all ones to 0 sets bit n of the overflow status at 0x740 on that edge. Writing 1 to a bit clears it. A wrap in the same cycle as its clear leaves the bit set.
- R8: When bit n at 0x96C is set, counter n also sets its overflow status bit when bit 31 goes from 0 to 1. Without that bit, a change of bit 31 sets nothing.
- R9: `irqOut` is high exactly while some overflow status bit and the matching interrupt-enable bit are both 1.
- R10: The per-counter control words at 0x120+8n, the saturate/roll word at 0x504 and the six filter words at 0x300..0x314 (4-byte step) read back what was written and do not affect counting. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 256 | Event lines, one per selector value |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid one cycle after `regRd` |
| regRdValid | output | 1 | High for the cycle in which `regRdata` holds read data |
| irqOut | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that `regWr` and `regRd` are never raised in the same cycle. They also assume that `regAddr` and `regWdata` stay stable in any cycle with a strobe. The bench drives every input at the falling edge and issues one register access per task call, so both assumptions hold. Event lines are raised only in idle cycles, or together with one deliberate write when checking write-over-increment and set-over-clear. Because of this, each counter's expected value follows from counting the rising edges during a pulse.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int CNT_N  = 8;
  localparam int CNT_W  = 32;
  localparam int EVT_N  = 256;
  localparam int SEL_W  = $clog2(EVT_N);
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int FLT_N  = 6;
  localparam int CNT_STRIDE = 8;
  localparam int FLT_STRIDE = 4;

  localparam logic [ADDR_W-1:0] A_CNT_VAL = 12'h420;
  localparam logic [ADDR_W-1:0] A_CNT_CTL = 12'h120;
  localparam logic [ADDR_W-1:0] A_EVT_SEL = 12'h220;
  localparam logic [ADDR_W-1:0] A_FLT     = 12'h300;
  localparam logic [ADDR_W-1:0] A_GCTL    = 12'h500;
  localparam logic [ADDR_W-1:0] A_SATROLL = 12'h504;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 12'h508;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 12'h50C;
  localparam logic [ADDR_W-1:0] A_IE_SET  = 12'h510;
  localparam logic [ADDR_W-1:0] A_IE_CLR  = 12'h514;
  localparam logic [ADDR_W-1:0] A_GANG    = 12'h718;
  localparam logic [ADDR_W-1:0] A_OVF     = 12'h740;
  localparam logic [ADDR_W-1:0] A_MSBIRQ  = 12'h96C;

  // Strobes and levels from the control side to the counters
  typedef struct packed {
    logic              bankClr;
    logic              globalEn;
    logic [CNT_N-1:0]  valWr;
    logic [CNT_N-1:0]  selWr;
    logic [CNT_N-1:0]  cntEn;
    logic [CNT_N-1:0]  gangEn;
    logic [CNT_N-1:0]  msbIrqEn;
    logic [DATA_W-1:0] wData;
  } dpCtl_t;

  // One-hot slot decode of an address inside a strided register array
  function automatic logic [CNT_N-1:0] slotHit(input logic [ADDR_W-1:0] addr,
                                               input logic [ADDR_W-1:0] base,
                                               input int stride, input int slots);
    logic [CNT_N-1:0] h;
    h = '0;
    for (int n = 0; n < CNT_N; n++)
      if (n < slots && addr == ADDR_W'(int'(base) + n * stride)) h[n] = 1'b1;
    return h;
  endfunction

  function automatic logic [CNT_N-1:0] oddMask();
    logic [CNT_N-1:0] m;
    for (int n = 0; n < CNT_N; n++) m[n] = (n % 2) == 1;
    return m;
  endfunction
endpackage

// File: rtl/evcnt_datapath.sv
module evcnt_datapath
  import evcnt_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCtl_t                       ctl,
  input  logic [EVT_N-1:0]             evtIn,
  output logic [CNT_N-1:0][CNT_W-1:0]  cntVal,
  output logic [CNT_N-1:0][SEL_W-1:0]  evtSel,
  output logic [CNT_N-1:0]             ovfEvt
);
  logic [CNT_N-1:0][CNT_W-1:0] cntQ;
  logic [CNT_N-1:0][SEL_W-1:0] selQ;
  logic [CNT_N-1:0] evtHit, srcPulse, step, carry, msbRise;

  for (genvar n = 0; n < CNT_N; n++) begin : g_cnt
    assign evtHit[n] = (selQ[n] != '0) && evtIn[selQ[n]];

    if (n % 2 == 1) begin : g_odd
      assign srcPulse[n] = ctl.gangEn[n] ? carry[n-1] : evtHit[n];
    end else begin : g_even
      assign srcPulse[n] = evtHit[n];
    end

    assign step[n]    = ctl.globalEn && ctl.cntEn[n] && srcPulse[n]
                        && !ctl.valWr[n] && !ctl.bankClr;
    assign carry[n]   = step[n] && (cntQ[n] == '1);
    assign msbRise[n] = step[n] && !cntQ[n][CNT_W-1] && (cntQ[n][CNT_W-2:0] == '1);
    assign ovfEvt[n]  = carry[n] || (ctl.msbIrqEn[n] && msbRise[n]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[n] <= '0;
        selQ[n] <= '0;
      end else begin
        if (ctl.bankClr)       cntQ[n] <= '0;
        else if (ctl.valWr[n]) cntQ[n] <= ctl.wData[CNT_W-1:0];
        else if (step[n])      cntQ[n] <= cntQ[n] + 1'b1;
        if (ctl.selWr[n])      selQ[n] <= ctl.wData[SEL_W-1:0];
      end
    end

    // R4
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ctl.globalEn && !ctl.valWr[n] && !ctl.bankClr) |=> $stable(cntQ[n]));

    // R5
    sw_write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.valWr[n] && !ctl.bankClr) |=> (cntQ[n] == $past(ctl.wData[CNT_W-1:0])));

    if (n % 2 == 1) begin : g_chain_chk
      // R6
      chain_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.gangEn[n] && carry[n-1] && ctl.globalEn && ctl.cntEn[n]
         && !ctl.valWr[n] && !ctl.bankClr) |=> (cntQ[n] == $past(cntQ[n]) + 1'b1));
      // R2
      sel_zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
        (selQ[n] == '0 && !ctl.gangEn[n] && !ctl.valWr[n] && !ctl.bankClr)
        |=> $stable(cntQ[n]));
    end else begin : g_even_chk
      // R2
      sel_zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
        (selQ[n] == '0 && !ctl.valWr[n] && !ctl.bankClr) |=> $stable(cntQ[n]));
    end
  end

  assign cntVal = cntQ;
  assign evtSel = selQ;
endmodule

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
  import evcnt_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  logic                         regRd,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [DATA_W-1:0]            regWdata,
  output logic [DATA_W-1:0]            regRdata,
  output logic                         regRdValid,
  input  logic [CNT_N-1:0][CNT_W-1:0]  cntVal,
  input  logic [CNT_N-1:0][SEL_W-1:0]  evtSel,
  input  logic [CNT_N-1:0]             ovfEvt,
  output dpCtl_t                       dpCtl,
  output logic                         irqOut
);
  localparam logic [CNT_N-1:0] ODD_BITS = oddMask();

  logic                     gEnQ;
  logic [CNT_N-1:0]         cntEnQ, intEnQ, gangQ, msbQ, ovfQ;
  logic [DATA_W-1:0]        satQ;
  logic [CNT_N-1:0][DATA_W-1:0] ctlQ;
  logic [FLT_N-1:0][DATA_W-1:0] fltQ;

  logic [CNT_N-1:0] valHit, ctlHit, selHit, fltHit;
  logic [CNT_N-1:0] wMask;
  logic             wrOvf;
  logic [DATA_W-1:0] rdNext;

  assign valHit = slotHit(regAddr, A_CNT_VAL, CNT_STRIDE, CNT_N);
  assign ctlHit = slotHit(regAddr, A_CNT_CTL, CNT_STRIDE, CNT_N);
  assign selHit = slotHit(regAddr, A_EVT_SEL, CNT_STRIDE, CNT_N);
  assign fltHit = slotHit(regAddr, A_FLT, FLT_STRIDE, FLT_N);
  assign wMask  = regWdata[CNT_N-1:0];
  assign wrOvf  = regWr && (regAddr == A_OVF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gEnQ   <= 1'b0;
      cntEnQ <= '0;
      intEnQ <= '0;
      gangQ  <= '0;
      msbQ   <= '0;
      ovfQ   <= '0;
      satQ   <= '0;
      ctlQ   <= '0;
      fltQ   <= '0;
    end else begin
      ovfQ <= (ovfQ & ~(wrOvf ? wMask : '0)) | ovfEvt;
      if (regWr) begin
        case (regAddr)
          A_GCTL:    gEnQ   <= regWdata[0];
          A_SATROLL: satQ   <= regWdata;
          A_EN_SET:  cntEnQ <= cntEnQ | wMask;
          A_EN_CLR:  cntEnQ <= cntEnQ & ~wMask;
          A_IE_SET:  intEnQ <= intEnQ | wMask;
          A_IE_CLR:  intEnQ <= intEnQ & ~wMask;
          A_GANG:    gangQ  <= wMask & ODD_BITS;
          A_MSBIRQ:  msbQ   <= wMask;
          default: ;
        endcase
        for (int n = 0; n < CNT_N; n++)
          if (ctlHit[n]) ctlQ[n] <= regWdata;
        for (int f = 0; f < FLT_N; f++)
          if (fltHit[f]) fltQ[f] <= regWdata;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    case (regAddr)
      A_GCTL:              rdNext[0] = gEnQ;
      A_SATROLL:           rdNext = satQ;
      A_EN_SET, A_EN_CLR:  rdNext[CNT_N-1:0] = cntEnQ;
      A_IE_SET, A_IE_CLR:  rdNext[CNT_N-1:0] = intEnQ;
      A_GANG:              rdNext[CNT_N-1:0] = gangQ;
      A_MSBIRQ:            rdNext[CNT_N-1:0] = msbQ;
      A_OVF:               rdNext[CNT_N-1:0] = ovfQ;
      default: ;
    endcase
    for (int n = 0; n < CNT_N; n++) begin
      if (valHit[n]) rdNext = DATA_W'(cntVal[n]);
      if (ctlHit[n]) rdNext = ctlQ[n];
      if (selHit[n]) rdNext = DATA_W'(evtSel[n]);
    end
    for (int f = 0; f < FLT_N; f++)
      if (fltHit[f]) rdNext = fltQ[f];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata   <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= regRd;
      if (regRd) regRdata <= rdNext;
    end
  end

  always_comb begin
    dpCtl          = '0;
    dpCtl.bankClr  = regWr && (regAddr == A_GCTL) && regWdata[1];
    dpCtl.globalEn = gEnQ;
    dpCtl.valWr    = regWr ? valHit : '0;
    dpCtl.selWr    = regWr ? selHit : '0;
    dpCtl.cntEn    = cntEnQ;
    dpCtl.gangEn   = gangQ;
    dpCtl.msbIrqEn = msbQ;
    dpCtl.wData    = regWdata;
  end

  assign irqOut = |(ovfQ & intEnQ);

  // R7
  ovf_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvt != '0) |=> ((ovfQ & $past(ovfEvt)) == $past(ovfEvt)));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrOvf |=> (($past(ovfQ) & ~ovfQ) == '0));

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == A_EN_SET) |=> ((cntEnQ & $past(wMask)) == $past(wMask)));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == A_EN_CLR) |=> ((cntEnQ & $past(wMask)) == '0));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrOvf && wMask == '1 && ovfEvt == '0) |=> !irqOut);
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_N-1:0]  evtIn,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRdValid,
  output logic              irqOut
);
  dpCtl_t                      dpCtl;
  logic [CNT_N-1:0][CNT_W-1:0] cntVal;
  logic [CNT_N-1:0][SEL_W-1:0] evtSel;
  logic [CNT_N-1:0]            ovfEvt;

  evcnt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regRdValid(regRdValid),
    .cntVal(cntVal), .evtSel(evtSel), .ovfEvt(ovfEvt), .dpCtl(dpCtl),
    .irqOut(irqOut)
  );

  evcnt_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .evtIn(evtIn),
    .cntVal(cntVal), .evtSel(evtSel), .ovfEvt(ovfEvt)
  );
endmodule

// File: tb/evcnt_bank_tb.sv
module evcnt_bank_tb;
  import evcnt_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [EVT_N-1:0] evtIn = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic regRdValid, irqOut;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] exp;
    string             tag;
  } rdItem_t;
  rdItem_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evcnt_bank u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regRdValid(regRdValid), .irqOut(irqOut)
  );

  // Monitor: pops the expected item for every returned read
  always @(negedge clk) begin
    if (rstN && regRdValid) begin
      checks++;
      if (sbq.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: unexpected read data %h", regRdata);
      end else begin
        rdItem_t it;
        it = sbq.pop_front();
        if (regRdata !== it.exp) begin
          failures++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, regRdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic wrWithEvt(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int sel);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d; evtIn[sel] = 1'b1;
    @(negedge clk); regWr = 1'b0; evtIn = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    rdItem_t it;
    @(negedge clk); regRd = 1'b1; regAddr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic pulse(input int sel, input int cycles);
    @(negedge clk); evtIn[sel] = 1'b1;
    repeat (cycles) @(negedge clk);
    evtIn = '0;
  endtask

  task automatic pulseAll(input int cycles);
    @(negedge clk); evtIn = '1;
    repeat (cycles) @(negedge clk);
    evtIn = '0;
  endtask

  task automatic chkIrq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irqOut !== e) begin
      failures++;
      $display("FAIL %s irqOut actual=%b expected=%b", tag, irqOut, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkIrq(1'b0, "R1");
    rd(12'h420, 32'h0, "R1 cnt0");
    rd(12'h740, 32'h0, "R1 ovf");
    rd(12'h508, 32'h0, "R1 cnten");
    rd(12'h718, 32'h0, "R1 gang");
    rd(12'h96C, 32'h0, "R1 msbmode");

    // R2 basic counting
    wr(12'h220, 32'h21);
    rd(12'h220, 32'h21, "R2 selector readback");
    wr(12'h508, 32'h1);
    wr(12'h500, 32'h1);
    pulse(8'h21, 5);
    rd(12'h420, 32'd5, "R2 cnt0 five events");
    wr(12'h508, 32'h2);
    pulseAll(3);
    rd(12'h428, 32'd0, "R2 selector zero");
    rd(12'h420, 32'd8, "R2 cnt0 all lines");

    // R3 set/clear masks
    rd(12'h50C, 32'h3, "R3 enable via clr addr");
    wr(12'h50C, 32'h1);
    wr(12'h508, 32'h0);
    rd(12'h508, 32'h2, "R3 enable after clr");
    pulse(8'h21, 2);
    rd(12'h420, 32'd8, "R3 disabled counter");
    wr(12'h510, 32'h81);
    wr(12'h514, 32'h80);
    rd(12'h514, 32'h1, "R3 int enable");

    // R4 global enable and bank reset
    wr(12'h508, 32'h1);
    wr(12'h500, 32'h0);
    pulse(8'h21, 4);
    rd(12'h420, 32'd8, "R4 frozen");
    wr(12'h500, 32'h1);
    pulse(8'h21, 1);
    rd(12'h420, 32'd9, "R4 resumed");
    wr(12'h500, 32'h3);
    rd(12'h420, 32'd0, "R4 bank clear");
    rd(12'h500, 32'h1, "R4 clear bit reads 0");

    // R5 write wins over increment
    wrWithEvt(12'h420, 32'h100, 8'h21);
    rd(12'h420, 32'h100, "R5 write wins");

    // R7 / R9 wrap, irq, clear
    wr(12'h420, 32'hFFFF_FFFE);
    pulse(8'h21, 2);
    chkIrq(1'b1, "R9 irq on enabled ovf");
    rd(12'h740, 32'h1, "R7 ovf set on wrap");
    rd(12'h420, 32'h0, "R7 wrapped value");
    wr(12'h740, 32'h1);
    chkIrq(1'b0, "R9 irq after clear");
    rd(12'h740, 32'h0, "R7 w1c");
    wr(12'h420, 32'hFFFF_FFFF);
    wrWithEvt(12'h740, 32'h1, 8'h21);
    rd(12'h740, 32'h1, "R7 set beats clear");
    wr(12'h740, 32'hFF);
    rd(12'h740, 32'h0, "R7 clear all");

    // R8 MSB toggle mode
    wr(12'h230, 32'h24);
    wr(12'h508, 32'h4);
    wr(12'h96C, 32'h4);
    wr(12'h430, 32'h7FFF_FFFF);
    pulse(8'h24, 1);
    rd(12'h430, 32'h8000_0000, "R8 cnt2 value");
    rd(12'h740, 32'h4, "R8 msb toggle flagged");
    chkIrq(1'b0, "R9 ovf without int enable");
    wr(12'h740, 32'hFF);
    wr(12'h420, 32'h7FFF_FFFF);
    pulse(8'h21, 1);
    rd(12'h740, 32'h0, "R8 no mode no flag");
    rd(12'h420, 32'h8000_0000, "R8 cnt0 value");

    // R6 chaining
    wr(12'h718, 32'hFF);
    rd(12'h718, 32'hAA, "R6 even gang bits dropped");
    wr(12'h238, 32'h24);
    wr(12'h508, 32'h8);
    wr(12'h430, 32'hFFFF_FFFE);
    wr(12'h438, 32'd5);
    pulse(8'h24, 3);
    rd(12'h430, 32'd1, "R6 lower half");
    rd(12'h438, 32'd6, "R6 upper counts carry only");
    rd(12'h740, 32'h4, "R6 only lower flagged");
    wr(12'h740, 32'hFF);
    wr(12'h718, 32'h0);
    pulse(8'h24, 2);
    rd(12'h438, 32'd8, "R6 unganged counts own event");

    // R10 storage and unmapped
    wr(12'h138, 32'hDEAD_BEEF);
    wr(12'h504, 32'h1234_5678);
    wr(12'h30C, 32'hA5A5_A5A5);
    wr(12'h314, 32'h0F0F_0F0F);
    rd(12'h138, 32'hDEAD_BEEF, "R10 control word");
    rd(12'h504, 32'h1234_5678, "R10 saturate word");
    rd(12'h30C, 32'hA5A5_A5A5, "R10 filter word");
    rd(12'h314, 32'h0F0F_0F0F, "R10 last filter");
    rd(12'h600, 32'h0, "R10 unmapped");
    rd(12'h124, 32'h0, "R10 gap");
    rd(12'h438, 32'd8, "R10 counting unaffected");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard: %0d reads never returned", sbq.size());
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule